// File: doc/BRIEF.md
# Packet Receive Net Decoder

This block sits at the receive side of a logic tile that talks to other tiles over a packet network. Fixed-size 40-bit packets arrive one per cycle from the link side through a valid/ready handshake and are queued in a small FIFO. Each cycle the decoder takes the oldest queued packet, compares its address field with the tile's own address, and, on a match, drives a set of local one-bit nets from the port-id/data slots carried in the packet.

A packet carries seven slots, so one packet can refresh up to seven different nets in the same cycle. Each net is a register that keeps the last value written to it. The tile's address and the set of port ids it listens to are fixed by parameters when the tile is built. Packets meant for another tile are dropped and counted in a saturating counter.

Top module: `netpkt_rx`

## Requirements
- R1: After reset every net output is 0, the mismatch count is 0 and pkt_ready_o is 1.
- R2: Packet layout: bits [39:28] hold the destination address; slot k (k = 0..6) occupies bits [4k+3:4k], with the port id in bits [4k+3:4k+1] and the data bit in bit 4k. When the address equals OWN_ADDR, net_o[pid] takes the slot's data bit.
- R3: All slots of one matching packet are applied together, so a single packet can change several nets in the same cycle.
- R4: A slot whose port id is 7 is empty and changes no net, whatever its data bit.
- R5: A slot whose port id has its bit cleared in ACCEPT_MASK changes no net; such a net stays 0 (default mask 7'b101_1111, so port id 5 is not listened to).
- R6: When two slots in one packet carry the same port id, the slot with the higher slot number sets the net.
- R7: A net keeps its value until a later matching packet addresses its port id.
- R8: A packet whose address differs from OWN_ADDR changes no net and increments mismatch_cnt_o by one.
- R9: mismatch_cnt_o saturates at 2**MISS_W-1 (15 by default) and stays there.
- R10: A packet is accepted on a rising edge where pkt_valid_i and pkt_ready_o are both 1; packets are applied in arrival order, one per cycle; the effect of a packet appears on the outputs after the second rising edge following its acceptance; pkt_ready_o is 0 only while the FIFO holds FIFO_DEPTH packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid_i | input | 1 | Link side offers a packet |
| pkt_data_i | input | 40 | Packet: address and seven port-id/data slots |
| pkt_ready_o | output | 1 | Decoder can accept a packet this cycle |
| net_o | output | 7 | Local net registers, one per port id 0..6 |
| mismatch_cnt_o | output | 4 | Saturating count of packets with a foreign address |

## Verification
The assertions take for granted that reset is held high from time zero through at least one rising edge and that pkt_data_i carries known values whenever pkt_valid_i is high, since the FIFO stores it unfiltered and the decoder compares its address directly. The stimulus keeps within this by raising reset before the first edge, changing inputs only on falling edges, and driving pkt_data_i only with fully defined packets built from constants. Back-to-back packets, foreign addresses, empty and unlisted port ids and repeated port ids are all sent through the normal handshake.

// File: rtl/netpkt_rx_pkg.sv
package netpkt_rx_pkg;

    localparam int ADDR_W    = 12;
    localparam int PID_W     = 3;
    localparam int SLOT_CNT  = 7;
    localparam int NET_CNT   = (1 << PID_W) - 1;
    localparam int PKT_W     = ADDR_W + SLOT_CNT * (PID_W + 1);
    localparam logic [PID_W-1:0] EMPTY_PID = '1;

    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic             data;
    } slot_t;

    typedef struct packed {
        logic [ADDR_W-1:0]          addr;
        slot_t [SLOT_CNT-1:0]       slots;
    } pkt_t;

    function automatic logic slot_live(slot_t s, logic [NET_CNT-1:0] mask);
        return (s.pid != EMPTY_PID) && mask[s.pid];
    endfunction

endpackage

// File: rtl/netpkt_fifo.sv
module netpkt_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    pop_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !do_push) |=> (count == $past(count) - 1'b1));

    // R10
    push_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (do_push && !do_pop) |=> (count == $past(count) + 1'b1) && !empty);

endmodule

// File: rtl/netpkt_apply.sv
module netpkt_apply
    import netpkt_rx_pkg::*;
#(
    parameter logic [ADDR_W-1:0]  OWN_ADDR    = 12'h5C3,
    parameter logic [NET_CNT-1:0] ACCEPT_MASK = 7'b101_1111
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  pkt_t               pkt,
    output logic [NET_CNT-1:0] net_q,
    output logic               miss
);
    logic               hit;
    logic [NET_CNT-1:0] net_d;

    assign hit  = take && (pkt.addr == OWN_ADDR);
    assign miss = take && (pkt.addr != OWN_ADDR);

    // Later slots are visited last, so they override earlier ones.
    always_comb begin
        net_d = net_q;
        for (int k = 0; k < SLOT_CNT; k++) begin
            if (slot_live(pkt.slots[k], ACCEPT_MASK))
                net_d[pkt.slots[k].pid] = pkt.slots[k].data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      net_q <= '0;
        else if (hit) net_q <= net_d;
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(net_q));

    // R8
    foreign_hold_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> $stable(net_q));

    // R5
    for (genvar g = 0; g < NET_CNT; g++) begin : g_unlisted
        if (!ACCEPT_MASK[g]) begin : g_off
            unlisted_zero_chk: assert property (@(posedge clk) disable iff (rst)
                net_q[g] == 1'b0);
        end
    end

endmodule

// File: rtl/netpkt_miss_ctr.sv
module netpkt_miss_ctr #(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [MISS_W-1:0] cnt
);
    localparam logic [MISS_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end

    // R8
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

    // R9
    miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |=> cnt == TOP);

endmodule

// File: rtl/netpkt_rx.sv
module netpkt_rx
    import netpkt_rx_pkg::*;
#(
    parameter logic [ADDR_W-1:0]  OWN_ADDR    = 12'h5C3,
    parameter logic [NET_CNT-1:0] ACCEPT_MASK = 7'b101_1111,
    parameter int                 FIFO_DEPTH  = 4,
    parameter int                 MISS_W      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_valid_i,
    input  logic [PKT_W-1:0]   pkt_data_i,
    output logic               pkt_ready_o,
    output logic [NET_CNT-1:0] net_o,
    output logic [MISS_W-1:0]  mismatch_cnt_o
);
    logic             fifo_full, fifo_empty, take, miss;
    logic [PKT_W-1:0] head;

    assign pkt_ready_o = !fifo_full;
    assign take        = !fifo_empty;

    netpkt_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (pkt_valid_i),
        .wdata (pkt_data_i),
        .pop   (take),
        .rdata (head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    netpkt_apply #(.OWN_ADDR(OWN_ADDR), .ACCEPT_MASK(ACCEPT_MASK)) u_apply (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .pkt   (pkt_t'(head)),
        .net_q (net_o),
        .miss  (miss)
    );

    netpkt_miss_ctr #(.MISS_W(MISS_W)) u_miss (
        .clk (clk),
        .rst (rst),
        .inc (miss),
        .cnt (mismatch_cnt_o)
    );

    // R10
    ready_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !pkt_valid_i) |=> pkt_ready_o);

endmodule

// File: tb/test_netpkt_rx.sv
module test_netpkt_rx;
    localparam logic [11:0] OWN  = 12'h5C3;
    localparam logic [6:0]  MASK = 7'b101_1111;
    localparam int          DEP  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid_i = 1'b0;
    logic [39:0] pkt_data_i = '0;
    logic        pkt_ready_o;
    logic [6:0]  net_o;
    logic [3:0]  mismatch_cnt_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    netpkt_rx i_netpkt_rx (
        .clk(clk), .rst(rst), .pkt_valid_i(pkt_valid_i), .pkt_data_i(pkt_data_i),
        .pkt_ready_o(pkt_ready_o), .net_o(net_o), .mismatch_cnt_o(mismatch_cnt_o)
    );

    // Behavioural reference model
    logic [39:0] q[$];
    logic [6:0]  m_net = '0;
    int          m_cnt = 0;

    always @(posedge clk) begin
        int sz;
        sz = q.size();
        if (rst) begin
            q.delete();
            m_net = '0;
            m_cnt = 0;
        end else begin
            if (sz > 0) begin
                logic [39:0] p;
                p = q.pop_front();
                if (p[39:28] == OWN) begin
                    for (int k = 0; k < 7; k++) begin
                        int pid;
                        pid = int'(p[4*k+1 +: 3]);
                        if (pid != 7 && MASK[pid]) m_net[pid] = p[4*k];
                    end
                end else if (m_cnt < 15) begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (pkt_valid_i && sz < DEP) q.push_back(pkt_data_i);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(net_o == m_net, "R2 model nets", int'(net_o), int'(m_net));
            chk(int'(mismatch_cnt_o) == m_cnt, "R8 model count", int'(mismatch_cnt_o), m_cnt);
            chk(pkt_ready_o == (q.size() < DEP), "R10 model ready", int'(pkt_ready_o), int'(q.size() < DEP));
        end
    end

    function automatic logic [3:0] sl(input int pid, input bit d);
        return {3'(pid), d};
    endfunction

    function automatic logic [39:0] mk(input logic [11:0] a,
        input logic [3:0] s6, input logic [3:0] s5, input logic [3:0] s4,
        input logic [3:0] s3, input logic [3:0] s2, input logic [3:0] s1,
        input logic [3:0] s0);
        return {a, s6, s5, s4, s3, s2, s1, s0};
    endfunction

    task automatic send(input logic [39:0] p);
        @(negedge clk);
        pkt_valid_i = 1'b1;
        pkt_data_i  = p;
        @(negedge clk);
        pkt_valid_i = 1'b0;
        pkt_data_i  = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [3:0] e;
        e = sl(7, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(net_o == 7'b0, "R1 nets after reset", int'(net_o), 0);
        chk(mismatch_cnt_o == 4'd0, "R1 count after reset", int'(mismatch_cnt_o), 0);
        chk(pkt_ready_o == 1'b1, "R1 ready after reset", int'(pkt_ready_o), 1);

        // R2 R3 R4: three nets set by one packet, empty slots carry data 1
        send(mk(OWN, e, e, e, e, sl(6, 1), sl(3, 1), sl(0, 1)));
        settle();
        chk(net_o == 7'b100_1001, "R3 multi-slot update", int'(net_o), 'h49);
        chk(net_o[2:1] == 2'b00 && net_o[4] == 1'b0, "R4 empty slots ignored", int'(net_o), 'h49);

        // R5: port id 5 not listened to
        send(mk(OWN, e, e, e, e, e, sl(5, 1), sl(5, 1)));
        settle();
        chk(net_o == 7'b100_1001, "R5 unlisted port ignored", int'(net_o), 'h49);

        // R6: repeated port id, higher slot wins
        send(mk(OWN, e, e, sl(2, 0), e, sl(1, 1), sl(2, 1), e));
        settle();
        chk(net_o == 7'b100_1011, "R6 higher slot wins (to 0)", int'(net_o), 'h4B);
        send(mk(OWN, sl(4, 1), e, e, e, e, e, sl(4, 0)));
        settle();
        chk(net_o == 7'b101_1011, "R6 higher slot wins (to 1)", int'(net_o), 'h5B);

        // R7: values held through idle cycles
        repeat (5) @(negedge clk);
        chk(net_o == 7'b101_1011, "R7 hold while idle", int'(net_o), 'h5B);

        // R8: foreign address
        send(mk(12'h5C2, sl(0, 0), sl(1, 0), sl(3, 0), sl(4, 0), sl(6, 0), sl(2, 1), sl(0, 0)));
        settle();
        chk(net_o == 7'b101_1011, "R8 foreign packet ignored", int'(net_o), 'h5B);
        chk(mismatch_cnt_o == 4'd1, "R8 count increments", int'(mismatch_cnt_o), 1);

        // R10: latency of two edges after acceptance
        @(negedge clk);
        pkt_valid_i = 1'b1;
        pkt_data_i  = mk(OWN, e, e, e, e, e, e, sl(6, 0));
        @(negedge clk);
        pkt_valid_i = 1'b0;
        chk(net_o[6] == 1'b1, "R10 no change after first edge", int'(net_o[6]), 1);
        @(negedge clk);
        chk(net_o[6] == 1'b0, "R10 change after second edge", int'(net_o[6]), 0);

        // R10: back-to-back packets applied in order
        @(negedge clk);
        pkt_valid_i = 1'b1;
        pkt_data_i  = mk(OWN, e, e, e, e, e, sl(1, 0), sl(0, 0));
        @(negedge clk);
        pkt_data_i  = mk(OWN, e, e, e, e, e, sl(1, 1), sl(0, 1));
        @(negedge clk);
        pkt_data_i  = mk(OWN, e, e, e, e, e, e, sl(0, 0));
        @(negedge clk);
        pkt_valid_i = 1'b0;
        chk(net_o[1:0] == 2'b11, "R10 second packet in order", int'(net_o[1:0]), 3);
        @(negedge clk);
        chk(net_o[1:0] == 2'b10, "R10 third packet in order", int'(net_o[1:0]), 2);
        chk(net_o[6:2] == 5'b0_0110, "R7 untouched nets kept", int'(net_o[6:2]), 6);

        // R9: saturation
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pkt_valid_i = 1'b1;
            pkt_data_i  = mk(12'h000, e, e, e, e, e, e, sl(0, 1));
        end
        @(negedge clk);
        pkt_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(mismatch_cnt_o == 4'd15, "R9 count saturates", int'(mismatch_cnt_o), 15);
        chk(net_o[0] == 1'b0, "R8 burst of foreign packets ignored", int'(net_o[0]), 0);

        // R2: field positions, single slot in the top slot
        send(mk(OWN, sl(3, 0), e, e, e, e, e, e));
        settle();
        chk(net_o == 7'b001_0010, "R2 top slot decoded", int'(net_o), 'h12);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule